// File: doc/BRIEF.md
# General-purpose I/O controller on an APB bus

This peripheral gives software control over up to four banks of general-purpose pins, each bank up to 32 lines wide. For every bank it holds an output value register and an output-enable (direction) register, and it drives the pad output and pad enable vectors from them. A read-only register per bank returns the pin levels after a two-flop synchronizer. Bank A also carries per-line interrupt logic and a per-line input filter. The interrupt logic can be set to level-sensitive or edge-sensitive with a selectable polarity, and it has enable, mask and status registers plus a write-one-to-clear acknowledge. Every unmasked, enabled status bit feeds one combined interrupt output.

Filtering runs on its own slow clock. A filtered line takes a new value only when the raw input has held that value for a set number of filter clock cycles, so short glitches never reach the readback register or the interrupt logic. A build parameter picks between two address layouts for the interrupt registers. Bus transfers finish with no wait states.

Top module: `gpio_apb_ctrl`

## Requirements
- R1: Bank p (p = 0..3) has its output value register at byte offset 12*p and its direction register at 12*p+4. Both are read/write and reset to zero. They drive pin_out and pin_oe bits [32p+31:32p] (1 = driven). A write to one bank leaves every other bank unchanged.
- R2: The pin readback register of bank p sits at 0x50+4*p. It returns pin_in of that bank after two bus-clock synchronizer flops. Writes to it are ignored.
- R3: A read of an offset with no register, and a read of the acknowledge register, returns zero. Every transfer completes in its access cycle.
- R4: A bank A line whose type bit is 0 is level-sensitive. Polarity bit 1 means active-high and 0 means active-low. Its status follows the synchronized input, and an acknowledge write has no effect on it.
- R5: A bank A line whose type bit is 1 is edge-sensitive. Polarity 1 catches rising edges and 0 catches falling edges. A caught edge stays latched until a 1 is written to that line's bit of the acknowledge register. Writing all ones clears every latched edge.
- R6: Each status bit is the raw condition AND the enable bit AND NOT the mask bit. A mask bit of 1 keeps its line off the irq output. irq is the OR of all status bits.
- R7: An edge that arrives while a line's enable bit is 0 is not latched. Setting the enable bit afterwards raises no interrupt.
- R8: With its filter-enable bit set, a bank A line (as seen in readback and in the interrupt logic) changes only after the raw input has held its new value for DB_CYCLES filter-clock cycles. Shorter pulses are dropped. Lines without the filter bit pass straight through.
- R9: Default layout (ALT_MAP=0): enable 0x30, mask 0x34, type 0x38, polarity 0x3c, status 0x40, filter enable 0x48, acknowledge 0x4c. With ALT_MAP=1: mask 0x44, type 0x34, polarity 0x38, status 0x3c, acknowledge 0x40, and enable and filter enable stay put. Under ALT_MAP=0, offset 0x44 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Synchronous active-low reset, bus domain |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| dbclk | input | 1 | Input filter clock |
| dbrstn | input | 1 | Synchronous active-low reset, filter domain |
| pin_in | input | NUM_PORTS*PORT_WIDTH | Pad input levels |
| pin_out | output | NUM_PORTS*PORT_WIDTH | Pad output values |
| pin_oe | output | NUM_PORTS*PORT_WIDTH | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds two copies of the block that share the bus signals and the pins and have separate selects. Both use four banks of 32 lines and DB_CYCLES of 4. One uses the default layout and the other the alternate one. Because all four banks are present, the 12-byte interleave and the readback registers can be checked across every bank. Running both layouts side by side shows that an offset valid in one is empty in the other. The short filter length keeps both the dropped-glitch case and the accepted-change case within a few hundred nanoseconds.

// File: rtl/gpio_apb_pkg.sv
// Shared constants and the interrupt register address layouts.
// Assumes byte addressing with 32-bit registers.
package gpio_apb_pkg;
    localparam int unsigned DATA_STRIDE = 12;
    localparam int unsigned DIR_OFFSET  = 4;
    localparam int unsigned EXT_BASE    = 'h50;
    localparam int unsigned EXT_STRIDE  = 4;

    typedef struct packed {
        logic [7:0] en;
        logic [7:0] mask;
        logic [7:0] typ;
        logic [7:0] pol;
        logic [7:0] sts;
        logic [7:0] deb;
        logic [7:0] ack;
    } irq_map_t;

    function automatic irq_map_t irq_map(input bit alt);
        irq_map_t m;
        m.en  = 8'h30;
        m.deb = 8'h48;
        if (alt) begin
            m.mask = 8'h44; m.typ = 8'h34; m.pol = 8'h38;
            m.sts  = 8'h3c; m.ack = 8'h40;
        end else begin
            m.mask = 8'h34; m.typ = 8'h38; m.pol = 8'h3c;
            m.sts  = 8'h40; m.ack = 8'h4c;
        end
        return m;
    endfunction
endpackage

// File: rtl/gpio_port_bank.sv
// One bank's output value and direction registers.
// Assumes the write strobes are already decoded and last one cycle.
module gpio_port_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rstn,
    input  logic         wr_dat,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dat_q,
    output logic [W-1:0] dir_q
);
    // Load the output value and direction registers from the bus.
    always_ff @(posedge clk) begin
        if (!rstn) begin
            dat_q <= '0;
            dir_q <= '0;
        end else begin
            if (wr_dat) dat_q <= wdata;
            if (wr_dir) dir_q <= wdata;
        end
    end
endmodule

// File: rtl/gpio_debounce.sv
// Per-line input filter clocked by the filter clock.
// Each line is synchronized with two flops. The output takes a new value only
// after the synchronized input has differed from it for DB_CYCLES cycles in a row.
module gpio_debounce #(
    parameter int W         = 32,
    parameter int DB_CYCLES = 16
) (
    input  logic         dbclk,
    input  logic         dbrstn,
    input  logic [W-1:0] raw,
    output logic [W-1:0] filt
);
    localparam int CW = $clog2(DB_CYCLES + 1);

    logic [W-1:0] meta_q, sync_q;

    // Bring the raw pins into the filter clock domain.
    always_ff @(posedge dbclk) begin
        if (!dbrstn) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        logic [CW-1:0] cnt_q;
        logic          f_q;
        // Count how long the input has differed and accept it once the count is full.
        always_ff @(posedge dbclk) begin
            if (!dbrstn) begin
                cnt_q <= '0;
                f_q   <= 1'b0;
            end else if (sync_q[i] != f_q) begin
                if (cnt_q == CW'(DB_CYCLES - 1)) begin
                    f_q   <= sync_q[i];
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
        assign filt[i] = f_q;
    end
endmodule

// File: rtl/gpio_irq_core.sv
// Bank A interrupt logic: level or edge detection, edge latches, status and
// the combined output. Assumes the line inputs are already synchronous to clk.
module gpio_irq_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rstn,
    input  logic [W-1:0] line,
    input  logic [W-1:0] en,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] typ,
    input  logic [W-1:0] pol,
    input  logic         ack_wr,
    input  logic [W-1:0] ack_bits,
    output logic [W-1:0] status,
    output logic         irq
);
    logic [W-1:0] line_d, lat_q, hit, lvl, clr;

    always_comb begin
        hit = typ & en & ((pol & line & ~line_d) | (~pol & ~line & line_d));
        lvl = ~(line ^ pol);
        clr = ack_wr ? ack_bits : '0;
    end

    // Keep the previous line value and latch edges; a new edge wins over a clear.
    always_ff @(posedge clk) begin
        if (!rstn) begin
            line_d <= '0;
            lat_q  <= '0;
        end else begin
            line_d <= line;
            lat_q  <= (lat_q & ~clr) | hit;
        end
    end

    assign status = ((typ & lat_q) | (~typ & lvl)) & en & ~mask;
    assign irq    = |status;
endmodule

// File: rtl/gpio_apb_ctrl.sv
// APB general-purpose I/O controller: NUM_PORTS banks of PORT_WIDTH lines,
// with interrupt and input filter logic on bank A only. Zero-wait-state bus,
// read data decoded combinationally. Assumes NUM_PORTS <= 4, PORT_WIDTH <= 32.
module gpio_apb_ctrl
    import gpio_apb_pkg::*;
#(
    parameter int NUM_PORTS  = 4,
    parameter int PORT_WIDTH = 32,
    parameter int ALT_MAP    = 0,
    parameter int DB_CYCLES  = 16,
    parameter int ADDR_W     = 8
) (
    input  logic                            pclk,
    input  logic                            presetn,
    input  logic                            psel,
    input  logic                            penable,
    input  logic                            pwrite,
    input  logic [ADDR_W-1:0]               paddr,
    input  logic [31:0]                     pwdata,
    output logic [31:0]                     prdata,
    input  logic                            dbclk,
    input  logic                            dbrstn,
    input  logic [NUM_PORTS*PORT_WIDTH-1:0] pin_in,
    output logic [NUM_PORTS*PORT_WIDTH-1:0] pin_out,
    output logic [NUM_PORTS*PORT_WIDTH-1:0] pin_oe,
    output logic                            irq
);
    localparam int       W     = PORT_WIDTH;
    localparam int       TOTAL = NUM_PORTS * PORT_WIDTH;
    localparam irq_map_t MAP   = irq_map(ALT_MAP != 0);

    logic         wr_en;
    logic [W-1:0] wbits;
    logic [W-1:0] dat_q [NUM_PORTS];
    logic [W-1:0] dir_q [NUM_PORTS];
    logic [W-1:0] ext_v [NUM_PORTS];
    logic [TOTAL-1:0] pin_m, pin_s;
    logic [W-1:0] db_filt, db_m, db_s, line_a;
    logic [W-1:0] en_q, mask_q, typ_q, pol_q, deb_q, status;
    logic         ack_wr;

    assign wr_en = psel && penable && pwrite;
    assign wbits = pwdata[W-1:0];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bank
        gpio_port_bank #(.W(W)) u_bank (
            .clk    (pclk),
            .rstn   (presetn),
            .wr_dat (wr_en && paddr == ADDR_W'(p * DATA_STRIDE)),
            .wr_dir (wr_en && paddr == ADDR_W'(p * DATA_STRIDE + DIR_OFFSET)),
            .wdata  (wbits),
            .dat_q  (dat_q[p]),
            .dir_q  (dir_q[p])
        );
        assign pin_out[p*W +: W] = dat_q[p];
        assign pin_oe[p*W +: W]  = dir_q[p];
        if (p == 0) begin : g_ext_a
            assign ext_v[p] = line_a;
        end else begin : g_ext_n
            assign ext_v[p] = pin_s[p*W +: W];
        end
    end

    // Synchronize all pad inputs and the filtered bank A lines into the bus domain.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            pin_m <= '0;
            pin_s <= '0;
            db_m  <= '0;
            db_s  <= '0;
        end else begin
            pin_m <= pin_in;
            pin_s <= pin_m;
            db_m  <= db_filt;
            db_s  <= db_m;
        end
    end

    gpio_debounce #(.W(W), .DB_CYCLES(DB_CYCLES)) u_deb (
        .dbclk  (dbclk),
        .dbrstn (dbrstn),
        .raw    (pin_in[W-1:0]),
        .filt   (db_filt)
    );

    assign line_a = (deb_q & db_s) | (~deb_q & pin_s[W-1:0]);

    // Bank A interrupt and filter configuration registers.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            en_q   <= '0;
            mask_q <= '0;
            typ_q  <= '0;
            pol_q  <= '0;
            deb_q  <= '0;
        end else if (wr_en) begin
            if (paddr == ADDR_W'(MAP.en))   en_q   <= wbits;
            if (paddr == ADDR_W'(MAP.mask)) mask_q <= wbits;
            if (paddr == ADDR_W'(MAP.typ))  typ_q  <= wbits;
            if (paddr == ADDR_W'(MAP.pol))  pol_q  <= wbits;
            if (paddr == ADDR_W'(MAP.deb))  deb_q  <= wbits;
        end
    end

    assign ack_wr = wr_en && paddr == ADDR_W'(MAP.ack);

    gpio_irq_core #(.W(W)) u_irq (
        .clk      (pclk),
        .rstn     (presetn),
        .line     (line_a),
        .en       (en_q),
        .mask     (mask_q),
        .typ      (typ_q),
        .pol      (pol_q),
        .ack_wr   (ack_wr),
        .ack_bits (wbits),
        .status   (status),
        .irq      (irq)
    );

    // Read data multiplexer; unmapped offsets return zero.
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (paddr == ADDR_W'(p * DATA_STRIDE))              prdata = 32'(dat_q[p]);
                if (paddr == ADDR_W'(p * DATA_STRIDE + DIR_OFFSET)) prdata = 32'(dir_q[p]);
                if (paddr == ADDR_W'(EXT_BASE + p * EXT_STRIDE))    prdata = 32'(ext_v[p]);
            end
            if (paddr == ADDR_W'(MAP.en))   prdata = 32'(en_q);
            if (paddr == ADDR_W'(MAP.mask)) prdata = 32'(mask_q);
            if (paddr == ADDR_W'(MAP.typ))  prdata = 32'(typ_q);
            if (paddr == ADDR_W'(MAP.pol))  prdata = 32'(pol_q);
            if (paddr == ADDR_W'(MAP.sts))  prdata = 32'(status);
            if (paddr == ADDR_W'(MAP.deb))  prdata = 32'(deb_q);
        end
    end
endmodule

// File: rtl/gpio_apb_chk.sv
// Property checker for gpio_apb_ctrl, attached with bind below.
// Observes bus, pads, irq and the bank A configuration registers.
module gpio_apb_chk #(
    parameter int W      = 32,
    parameter int AW     = 8,
    parameter int TOTAL  = 128
) (
    input logic             pclk,
    input logic             presetn,
    input logic             psel,
    input logic             penable,
    input logic             pwrite,
    input logic [AW-1:0]    paddr,
    input logic [31:0]      prdata,
    input logic [TOTAL-1:0] pin_out,
    input logic [TOTAL-1:0] pin_oe,
    input logic             irq,
    input logic [W-1:0]     en_q,
    input logic [W-1:0]     mask_q,
    input logic [W-1:0]     typ_q
);
    logic bus_wr;
    assign bus_wr = psel && penable && pwrite;

    AST_PADS_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
        !bus_wr |=> ($stable(pin_out) && $stable(pin_oe))); // R1

    AST_HIGH_READ_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !pwrite && paddr >= AW'(8'h60)) |-> (prdata == 32'h0)); // R3

    AST_EDGE_HELD: assert property (@(posedge pclk) disable iff (!presetn)
        (irq && !bus_wr && ((en_q & ~typ_q) == '0)) |=> irq); // R5

    AST_MASK_BLOCKS: assert property (@(posedge pclk) disable iff (!presetn)
        ((en_q & ~mask_q) == '0) |-> !irq); // R6
endmodule

bind gpio_apb_ctrl gpio_apb_chk #(
    .W(PORT_WIDTH), .AW(ADDR_W), .TOTAL(NUM_PORTS * PORT_WIDTH)
) u_chk (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .prdata(prdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq), .en_q(en_q), .mask_q(mask_q), .typ_q(typ_q)
);

// File: tb/gpio_apb_ctrl_tb_top.sv
// Directed bench: dut_i uses the default layout, alt_i the alternate one.
module gpio_apb_ctrl_tb_top;
    logic         pclk = 0, dbclk = 0;
    logic         presetn = 0, dbrstn = 0;
    logic         psel_a = 0, psel_b = 0, penable = 0, pwrite = 0;
    logic [7:0]   paddr = '0;
    logic [31:0]  pwdata = '0;
    logic [31:0]  prdata_a, prdata_b;
    logic [127:0] pin_in = '0;
    logic [127:0] out_a, oe_a, out_b, oe_b;
    logic         irq_a, irq_b;
    int           n_chk = 0, n_fail = 0;
    bit           done = 0;

    always #4  pclk  = ~pclk;
    always #10 dbclk = ~dbclk;

    gpio_apb_ctrl #(.NUM_PORTS(4), .PORT_WIDTH(32), .ALT_MAP(0), .DB_CYCLES(4)) dut_i (
        .pclk(pclk), .presetn(presetn), .psel(psel_a), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a),
        .dbclk(dbclk), .dbrstn(dbrstn), .pin_in(pin_in), .pin_out(out_a),
        .pin_oe(oe_a), .irq(irq_a));

    gpio_apb_ctrl #(.NUM_PORTS(4), .PORT_WIDTH(32), .ALT_MAP(1), .DB_CYCLES(4)) alt_i (
        .pclk(pclk), .presetn(presetn), .psel(psel_b), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_b),
        .dbclk(dbclk), .dbrstn(dbrstn), .pin_in(pin_in), .pin_out(out_b),
        .pin_oe(oe_b), .irq(irq_b));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge pclk);
    endtask

    task automatic bus_wr(input bit alt, input logic [7:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel_a = !alt; psel_b = alt; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge pclk);
        penable = 1;
        @(negedge pclk);
        psel_a = 0; psel_b = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_rd(input bit alt, input logic [7:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel_a = !alt; psel_b = alt; pwrite = 0; paddr = a; penable = 0;
        @(negedge pclk);
        penable = 1;
        #1 d = alt ? prdata_b : prdata_a;
        @(negedge pclk);
        psel_a = 0; psel_b = 0; penable = 0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_rd(0, 8'h00, d); check("R1 reset data", d, 0);
        bus_rd(0, 8'h04, d); check("R1 reset dir", d, 0);
        bus_rd(0, 8'h30, d); check("R6 reset enable", d, 0);
        check("R1 reset oe", oe_a[31:0], 0);
        check("R6 reset irq", {31'b0, irq_a}, 0);
    endtask

    task automatic t_banks;
        logic [31:0] d;
        bus_wr(0, 8'h0c, 32'hA5A5_0001);
        bus_wr(0, 8'h10, 32'hFFFF_0000);
        bus_wr(0, 8'h24, 32'hDEAD_BEEF);
        bus_rd(0, 8'h0c, d); check("R1 bank B data", d, 32'hA5A5_0001);
        bus_rd(0, 8'h10, d); check("R1 bank B dir", d, 32'hFFFF_0000);
        check("R1 bank B pin_out", out_a[63:32], 32'hA5A5_0001);
        check("R1 bank B pin_oe", oe_a[63:32], 32'hFFFF_0000);
        check("R1 bank D pin_out", out_a[127:96], 32'hDEAD_BEEF);
        bus_rd(0, 8'h00, d); check("R1 bank A untouched", d, 0);
        bus_rd(0, 8'h18, d); check("R1 bank C untouched", d, 0);
    endtask

    task automatic t_ext;
        logic [31:0] d;
        pin_in[95:64] = 32'h1234_5678;
        wait_clk(4);
        bus_rd(0, 8'h58, d); check("R2 bank C readback", d, 32'h1234_5678);
        bus_wr(0, 8'h58, 32'h0);
        bus_rd(0, 8'h58, d); check("R2 readback write ignored", d, 32'h1234_5678);
        bus_rd(0, 8'h54, d); check("R2 bank B readback", d, 0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        bus_rd(0, 8'h60, d); check("R3 offset 0x60", d, 0);
        bus_rd(0, 8'h08, d); check("R3 offset 0x08", d, 0);
        bus_rd(0, 8'h4c, d); check("R3 ack reads zero", d, 0);
        bus_rd(0, 8'h44, d); check("R9 0x44 empty in default map", d, 0);
    endtask

    task automatic t_level;
        logic [31:0] d;
        bus_wr(0, 8'h3c, 32'h1);
        bus_wr(0, 8'h38, 32'h0);
        bus_wr(0, 8'h30, 32'h1);
        wait_clk(2);
        check("R4 level low idle", {31'b0, irq_a}, 0);
        pin_in[0] = 1; wait_clk(4);
        check("R4 active-high irq", {31'b0, irq_a}, 1);
        bus_rd(0, 8'h40, d); check("R4 status", d, 32'h1);
        bus_wr(0, 8'h4c, 32'h1); wait_clk(2);
        check("R4 ack ignored by level", {31'b0, irq_a}, 1);
        pin_in[0] = 0; wait_clk(4);
        check("R4 level follows input", {31'b0, irq_a}, 0);
        bus_wr(0, 8'h30, 32'h2); wait_clk(2);
        bus_rd(0, 8'h40, d); check("R4 active-low status", d, 32'h2);
        bus_wr(0, 8'h30, 32'h0);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        bus_wr(0, 8'h30, 32'h1);
        pin_in[0] = 1; wait_clk(4);
        check("R6 unmasked irq", {31'b0, irq_a}, 1);
        bus_wr(0, 8'h34, 32'h1); wait_clk(1);
        check("R6 masked irq", {31'b0, irq_a}, 0);
        bus_rd(0, 8'h40, d); check("R6 masked status", d, 0);
        bus_wr(0, 8'h34, 32'h0); wait_clk(1);
        check("R6 unmask restores", {31'b0, irq_a}, 1);
        pin_in[0] = 0;
        bus_wr(0, 8'h30, 32'h0);
    endtask

    task automatic t_edge;
        logic [31:0] d;
        bus_wr(0, 8'h38, 32'hC);
        bus_wr(0, 8'h3c, 32'h4);
        pin_in[3] = 1; wait_clk(4);
        bus_wr(0, 8'h30, 32'h4);
        pin_in[2] = 1; wait_clk(4); pin_in[2] = 0; wait_clk(10);
        check("R5 rising latched", {31'b0, irq_a}, 1);
        bus_rd(0, 8'h40, d); check("R5 rising status", d, 32'h4);
        bus_wr(0, 8'h4c, 32'h4); wait_clk(2);
        check("R5 ack clears", {31'b0, irq_a}, 0);
        bus_wr(0, 8'h30, 32'hC);
        pin_in[3] = 0; wait_clk(4);
        pin_in[2] = 1; wait_clk(4); pin_in[2] = 0; wait_clk(4);
        bus_rd(0, 8'h40, d); check("R5 falling and rising", d, 32'hC);
        bus_wr(0, 8'h4c, 32'hFFFF_FFFF); wait_clk(2);
        bus_rd(0, 8'h40, d); check("R5 ack all ones", d, 0);
        bus_wr(0, 8'h30, 32'h0);
    endtask

    task automatic t_disabled;
        logic [31:0] d;
        pin_in[2] = 1; wait_clk(4); pin_in[2] = 0; wait_clk(4);
        bus_wr(0, 8'h30, 32'h4); wait_clk(2);
        check("R7 no latch while disabled", {31'b0, irq_a}, 0);
        bus_rd(0, 8'h40, d); check("R7 status clear", d, 0);
        bus_wr(0, 8'h30, 32'h0);
    endtask

    task automatic t_filter;
        logic [31:0] d;
        bus_wr(0, 8'h48, 32'h10);
        bus_rd(0, 8'h48, d); check("R8 filter enable readback", d, 32'h10);
        wait_clk(20);
        pin_in[4] = 1; #30; pin_in[4] = 0;
        wait_clk(50);
        bus_rd(0, 8'h50, d); check("R8 glitch dropped", d, 0);
        pin_in[4] = 1; pin_in[5] = 1;
        wait_clk(4);
        bus_rd(0, 8'h50, d); check("R8 early: only unfiltered line", d, 32'h20);
        wait_clk(60);
        bus_rd(0, 8'h50, d); check("R8 stable change accepted", d, 32'h30);
        pin_in[5:4] = 2'b00;
        wait_clk(60);
    endtask

    task automatic t_alt;
        logic [31:0] d;
        bus_wr(1, 8'h30, 32'h1);
        bus_wr(1, 8'h34, 32'h0);
        bus_wr(1, 8'h38, 32'h1);
        pin_in[0] = 1; wait_clk(4);
        bus_rd(1, 8'h3c, d); check("R9 alt status", d, 32'h1);
        check("R9 alt irq", {31'b0, irq_b}, 1);
        check("R9 default copy unconfigured", {31'b0, irq_a}, 0);
        bus_wr(1, 8'h44, 32'h1); wait_clk(1);
        check("R9 alt mask", {31'b0, irq_b}, 0);
        bus_rd(1, 8'h44, d); check("R9 alt mask readback", d, 32'h1);
        bus_rd(1, 8'h40, d); check("R9 alt ack reads zero", d, 0);
        pin_in[0] = 0;
        bus_wr(1, 8'h30, 32'h0);
    endtask

    initial begin
        wait_clk(5);
        presetn = 1; dbrstn = 1;
        wait_clk(2);
        t_reset();
        t_banks();
        t_ext();
        t_unmapped();
        t_level();
        t_mask();
        t_edge();
        t_disabled();
        t_filter();
        t_alt();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge pclk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule